// File: doc/BRIEF.md
# Open-Page Banked DRAM Command Sequencer

This block sits between a single word-wide request port and a banked DRAM device. Each accepted request, whether read, write or read-modify-write, is broken into the primitive device commands: close the current page (precharge), open a new row (activate), and a column read or column write. The block keeps a table with one entry per bank. Each entry holds an open flag and the row that currently sits in that bank's page buffer. A request whose row is already open goes straight to the column command, and pages stay open across requests in every bank at once.

Requests are taken one at a time and completed in arrival order, and at most one command leaves the block per cycle. Two spacing rules are enforced by a single down-counter: the precharge-to-activate gap and the activate-to-column gap, each a parameter in cycles. A read-modify-write reads the word and combines it with the request operand using a small function code. It then writes the result back to the same column of the still-open row and returns that result on the response port.

Top module: `dramc_top`

## Requirements
- R1: The request address is split as {row, bank, column}: column = bits [COL_W-1:0], bank = the next BANK_W bits, row = the top ROW_W bits. The commands for a request carry exactly these fields.
- R2: After reset every bank is closed, req_ready is high, cmd_code is NOP (code 0) and rsp_valid is low.
- R3: A request to a closed bank issues activate (code 2) and then its column command, with no precharge before it.
- R4: A request whose row is open in its bank issues only the column command: read (code 3) or write (code 4).
- R5: A request to a bank open on a different row issues precharge (code 1), then activate, then the column command, in that order and to the same bank. An activate never targets a bank that is open.
- R6: Opening or closing a row in one bank leaves the open row of every other bank unchanged.
- R7: An activate that follows a precharge comes exactly T_RP cycles after it, and a column command comes exactly T_RCD cycles after the activate of the same request.
- R8: A write (req_op 1) sends req_wdata with the write command and gives no response. A later read of that address returns the written word.
- R9: A read (req_op 0, with code 3 treated the same) returns the device word on rsp_data with a single-cycle rsp_valid pulse, in the cycle after dram_rvalid.
- R10: A read-modify-write (req_op 2) issues the column read and then exactly one column write to the same address, with no precharge or activate between them. The written and returned value is read+operand for req_fn 0, read|operand for req_fn 1, read&operand for req_fn 2, and the read value unchanged for req_fn 3.
- R11: req_ready drops the cycle after a request is accepted and stays low until that request has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | 0 read, 1 write, 2 read-modify-write, 3 read |
| req_fn | input | 2 | Modify function: 0 add, 1 OR, 2 AND, 3 pass |
| req_addr | input | ROW_W+BANK_W+COL_W | Word address {row, bank, column} |
| req_wdata | input | DATA_W | Write data or modify operand |
| rsp_valid | output | 1 | Response word valid (one cycle) |
| rsp_data | output | DATA_W | Read word or modified result |
| cmd_code | output | 3 | 0 NOP, 1 precharge, 2 activate, 3 read, 4 write |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_row | output | ROW_W | Row of the command |
| cmd_col | output | COL_W | Column of the command |
| cmd_wdata | output | DATA_W | Data that goes with a write command |
| dram_rvalid | input | 1 | Device read data present |
| dram_rdata | input | DATA_W | Device read data |

## Verification
The assertions assume that the device raises dram_rvalid once per column read and only while the block is waiting for it. They also assume that the request fields stay unchanged while req_valid is high and ready is low. The bench's device model returns each read a fixed two cycles after the read command and never otherwise, and the bench drives one request at a time. The model keeps its own open-row state per bank and indexes its storage with it. A skipped or misdirected activate therefore turns into a wrong data word as well as a protocol error flagged by the monitor.

// File: rtl/dramc_pkg.sv
package dramc_pkg;

   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_PRE = 3'd1,
      CMD_ACT = 3'd2,
      CMD_RD  = 3'd3,
      CMD_WR  = 3'd4
   } dcmd_e;

   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_WRITE = 2'd1,
      OP_RMW   = 2'd2,
      OP_RSVD  = 2'd3
   } dop_e;

   typedef enum logic [1:0] {
      FN_ADD  = 2'd0,
      FN_OR   = 2'd1,
      FN_AND  = 2'd2,
      FN_PASS = 2'd3
   } dfn_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_ACT,
      ST_COL,
      ST_RDW,
      ST_WB
   } dst_e;

endpackage

// File: rtl/dramc_wait_timer.sv
module dramc_wait_timer #(
   parameter int TW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          zero
);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   AST_LOAD_WHEN_EXPIRED: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (cnt_q == '0)); // R7

endmodule

// File: rtl/dramc_bank_table.sv
module dramc_bank_table #(
   parameter int BANK_W = 2,
   parameter int ROW_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] lk_bank,
   input  logic [ROW_W-1:0]  lk_row,
   output logic              lk_open,
   output logic              lk_hit,
   input  logic              act_en,
   input  logic              pre_en,
   input  logic [BANK_W-1:0] upd_bank,
   input  logic [ROW_W-1:0]  act_row
);

   localparam int NBANK = 1 << BANK_W;

   logic             open_q [NBANK];
   logic [ROW_W-1:0] row_q  [NBANK];

   for (genvar g = 0; g < NBANK; g++) begin : g_bank
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            open_q[g] <= 1'b0;
            row_q[g]  <= '0;
         end else if (act_en && upd_bank == BANK_W'(g)) begin
            open_q[g] <= 1'b1;
            row_q[g]  <= act_row;
         end else if (pre_en && upd_bank == BANK_W'(g)) begin
            open_q[g] <= 1'b0;
         end
      end

      AST_ACT_ON_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
         (act_en && upd_bank == BANK_W'(g)) |-> !open_q[g]); // R5

      AST_OTHER_BANK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
         ((act_en || pre_en) && upd_bank != BANK_W'(g)) |=> $stable(row_q[g]) && $stable(open_q[g])); // R6
   end

   assign lk_open = open_q[lk_bank];
   assign lk_hit  = open_q[lk_bank] && (row_q[lk_bank] == lk_row);

endmodule

// File: rtl/dramc_rmw_alu.sv
module dramc_rmw_alu #(
   parameter int DATA_W = 16
) (
   input  logic [1:0]        fn,
   input  logic [DATA_W-1:0] rd_word,
   input  logic [DATA_W-1:0] operand,
   output logic [DATA_W-1:0] result
);
   import dramc_pkg::*;

   always_comb begin
      unique case (dfn_e'(fn))
         FN_ADD:  result = rd_word + operand;
         FN_OR:   result = rd_word | operand;
         FN_AND:  result = rd_word & operand;
         default: result = rd_word;
      endcase
   end

endmodule

// File: rtl/dramc_top.sv
module dramc_top #(
   parameter int DATA_W = 16,
   parameter int ROW_W  = 4,
   parameter int BANK_W = 2,
   parameter int COL_W  = 3,
   parameter int T_RP   = 2,
   parameter int T_RCD  = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            req_valid,
   output logic                            req_ready,
   input  logic [1:0]                      req_op,
   input  logic [1:0]                      req_fn,
   input  logic [ROW_W+BANK_W+COL_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]               req_wdata,
   output logic                            rsp_valid,
   output logic [DATA_W-1:0]               rsp_data,
   output logic [2:0]                      cmd_code,
   output logic [BANK_W-1:0]               cmd_bank,
   output logic [ROW_W-1:0]                cmd_row,
   output logic [COL_W-1:0]                cmd_col,
   output logic [DATA_W-1:0]               cmd_wdata,
   input  logic                            dram_rvalid,
   input  logic [DATA_W-1:0]               dram_rdata
);
   import dramc_pkg::*;

   localparam int TMAX = (T_RP > T_RCD) ? T_RP : T_RCD;
   localparam int TW   = $clog2(TMAX + 1);
   localparam int CW   = $clog2(TMAX + 2);

   if (T_RP < 1 || T_RCD < 1) begin : g_bad_timing
      $error("dramc_top: T_RP and T_RCD must be at least 1");
   end
   if (ROW_W < 1 || BANK_W < 1 || COL_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("dramc_top: address and data fields need at least one bit");
   end

   dst_e               st_q, st_d;
   dop_e               op_q;
   logic [1:0]         fn_q;
   logic [ROW_W-1:0]   row_q;
   logic [BANK_W-1:0]  bank_q;
   logic [COL_W-1:0]   col_q;
   logic [DATA_W-1:0]  wd_q, wb_q;
   logic               rsp_valid_q;
   logic [DATA_W-1:0]  rsp_data_q;

   logic [COL_W-1:0]   in_col;
   logic [BANK_W-1:0]  in_bank;
   logic [ROW_W-1:0]   in_row;
   logic [BANK_W-1:0]  lk_bank;
   logic [ROW_W-1:0]   lk_row;
   logic               lk_open, lk_hit;
   logic               tmr_zero, tmr_load;
   logic [TW-1:0]      tmr_val;
   logic               pre_fire, act_fire, col_fire, wb_fire, accept;
   logic [DATA_W-1:0]  alu_out;

   assign in_col  = req_addr[COL_W-1:0];
   assign in_bank = req_addr[COL_W +: BANK_W];
   assign in_row  = req_addr[COL_W+BANK_W +: ROW_W];

   assign req_ready = (st_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign lk_bank   = req_ready ? in_bank : bank_q;
   assign lk_row    = req_ready ? in_row  : row_q;

   assign pre_fire = (st_q == ST_PRE);
   assign act_fire = (st_q == ST_ACT) && tmr_zero;
   assign col_fire = (st_q == ST_COL) && tmr_zero;
   assign wb_fire  = (st_q == ST_WB);

   assign tmr_load = pre_fire || act_fire;
   assign tmr_val  = pre_fire ? TW'(T_RP - 1) : TW'(T_RCD - 1);

   dramc_bank_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_bank  (lk_bank),
      .lk_row   (lk_row),
      .lk_open  (lk_open),
      .lk_hit   (lk_hit),
      .act_en   (act_fire),
      .pre_en   (pre_fire),
      .upd_bank (bank_q),
      .act_row  (row_q)
   );

   dramc_wait_timer #(.TW(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   dramc_rmw_alu #(.DATA_W(DATA_W)) u_alu (
      .fn      (fn_q),
      .rd_word (dram_rdata),
      .operand (wd_q),
      .result  (alu_out)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (req_valid)
                     st_d = lk_hit ? ST_COL : (lk_open ? ST_PRE : ST_ACT);
         ST_PRE:  st_d = ST_ACT;
         ST_ACT:  if (act_fire) st_d = ST_COL;
         ST_COL:  if (col_fire) st_d = (op_q == OP_WRITE) ? ST_IDLE : ST_RDW;
         ST_RDW:  if (dram_rvalid) st_d = (op_q == OP_RMW) ? ST_WB : ST_IDLE;
         ST_WB:   st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         op_q        <= OP_READ;
         fn_q        <= '0;
         row_q       <= '0;
         bank_q      <= '0;
         col_q       <= '0;
         wd_q        <= '0;
         wb_q        <= '0;
         rsp_valid_q <= 1'b0;
         rsp_data_q  <= '0;
      end else begin
         st_q        <= st_d;
         rsp_valid_q <= 1'b0;
         if (accept) begin
            op_q   <= dop_e'(req_op);
            fn_q   <= req_fn;
            row_q  <= in_row;
            bank_q <= in_bank;
            col_q  <= in_col;
            wd_q   <= req_wdata;
         end
         if (st_q == ST_RDW && dram_rvalid) begin
            if (op_q == OP_RMW) begin
               wb_q <= alu_out;
            end else begin
               rsp_valid_q <= 1'b1;
               rsp_data_q  <= dram_rdata;
            end
         end
         if (wb_fire) begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= wb_q;
         end
      end
   end

   always_comb begin
      cmd_code = CMD_NOP;
      if (pre_fire)      cmd_code = CMD_PRE;
      else if (act_fire) cmd_code = CMD_ACT;
      else if (col_fire) cmd_code = (op_q == OP_WRITE) ? CMD_WR : CMD_RD;
      else if (wb_fire)  cmd_code = CMD_WR;
   end

   assign cmd_bank  = bank_q;
   assign cmd_row   = row_q;
   assign cmd_col   = col_q;
   assign cmd_wdata = wb_fire ? wb_q : wd_q;
   assign rsp_valid = rsp_valid_q;
   assign rsp_data  = rsp_data_q;

   // spacing checker: cycles since the last precharge / activate
   logic [CW-1:0] since_pre, since_act;
   logic          after_pre, after_act;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_pre <= '0;
         since_act <= '0;
         after_pre <= 1'b0;
         after_act <= 1'b0;
      end else begin
         if (pre_fire) since_pre <= CW'(1);
         else if (since_pre != '1) since_pre <= since_pre + 1'b1;
         if (act_fire) since_act <= CW'(1);
         else if (since_act != '1) since_act <= since_act + 1'b1;
         if (pre_fire) after_pre <= 1'b1;
         else if (act_fire) after_pre <= 1'b0;
         if (act_fire) after_act <= 1'b1;
         else if (col_fire) after_act <= 1'b0;
      end
   end

   AST_TRP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (act_fire && after_pre) |-> (since_pre == CW'(T_RP))); // R7
   AST_TRCD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (col_fire && after_act) |-> (since_act == CW'(T_RCD))); // R7
   AST_COL_ROW_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (col_fire || wb_fire) |-> lk_hit); // R4
   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready); // R11
   AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R9
   AST_RVALID_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n)
      dram_rvalid |-> (st_q == ST_RDW)); // R9
   AST_WB_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      wb_fire |-> ($past(st_q) == ST_RDW)); // R10

endmodule

// File: tb/dramc_top_bench.sv
module dramc_top_bench;
   import dramc_pkg::*;

   localparam int CLK_NS = 10;
   localparam int DATA_W = 16;
   localparam int ROW_W  = 4;
   localparam int BANK_W = 2;
   localparam int COL_W  = 3;
   localparam int T_RP   = 2;
   localparam int T_RCD  = 3;
   localparam int ADDR_W = ROW_W + BANK_W + COL_W;
   localparam int NWORD  = 1 << ADDR_W;
   localparam int NBANK  = 1 << BANK_W;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_ready;
   logic [1:0] req_op = '0, req_fn = '0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic rsp_valid;
   logic [DATA_W-1:0] rsp_data;
   logic [2:0] cmd_code;
   logic [BANK_W-1:0] cmd_bank;
   logic [ROW_W-1:0] cmd_row;
   logic [COL_W-1:0] cmd_col;
   logic [DATA_W-1:0] cmd_wdata;
   logic dram_rvalid;
   logic [DATA_W-1:0] dram_rdata;

   int total = 0, bad = 0, cyc = 0;

   always #(CLK_NS/2) clk = ~clk;

   dramc_top #(.DATA_W(DATA_W), .ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W),
               .T_RP(T_RP), .T_RCD(T_RCD)) u_dramc_top (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_fn(req_fn), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .cmd_code(cmd_code),
      .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_wdata(cmd_wdata),
      .dram_rvalid(dram_rvalid), .dram_rdata(dram_rdata));

   function automatic logic [DATA_W-1:0] init_word(int a);
      return DATA_W'(a * 37 + 5);
   endfunction

   function automatic logic [ADDR_W-1:0] mk(int row, int bank, int col);
      return {ROW_W'(row), BANK_W'(bank), COL_W'(col)};
   endfunction

   // device model with its own page state, read latency two cycles
   logic [DATA_W-1:0] mem [NWORD];
   logic              m_open [NBANK];
   logic [ROW_W-1:0]  m_row  [NBANK];
   logic              r1, r2;
   logic [DATA_W-1:0] d1, d2;
   assign dram_rvalid = r2;
   assign dram_rdata  = d2;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NWORD; i++) mem[i] <= init_word(i);
         for (int b = 0; b < NBANK; b++) begin m_open[b] <= 1'b0; m_row[b] <= '0; end
         r1 <= 1'b0; r2 <= 1'b0; d1 <= '0; d2 <= '0;
      end else begin
         r1 <= (cmd_code == CMD_RD);
         d1 <= mem[{m_row[cmd_bank], cmd_bank, cmd_col}];
         r2 <= r1;
         d2 <= d1;
         if (cmd_code == CMD_WR) mem[{m_row[cmd_bank], cmd_bank, cmd_col}] <= cmd_wdata;
         if (cmd_code == CMD_ACT) begin m_open[cmd_bank] <= 1'b1; m_row[cmd_bank] <= cmd_row; end
         if (cmd_code == CMD_PRE) m_open[cmd_bank] <= 1'b0;
      end
   end

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string r, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", r, act, exp);
      end
   endtask

   // command log for the current request
   int log_n = 0;
   logic [2:0] log_code [8];
   int log_cyc [8];
   logic [ROW_W-1:0] last_row;
   logic [BANK_W-1:0] last_bank;
   logic [COL_W-1:0] last_col;
   int pre_cyc [NBANK];
   int act_cyc [NBANK];
   bit pre_seen [NBANK];

   always @(negedge clk) begin
      if (rst_n && cmd_code != CMD_NOP) begin
         if (log_n < 8) begin log_code[log_n] = cmd_code; log_cyc[log_n] = cyc; log_n++; end
         if (cmd_code == CMD_ACT) begin
            chk(!m_open[cmd_bank], "R5 activate to closed bank", m_open[cmd_bank], 0);
            if (pre_seen[cmd_bank])
               chk(cyc - pre_cyc[cmd_bank] >= T_RP, "R7 precharge gap", cyc - pre_cyc[cmd_bank], T_RP);
            act_cyc[cmd_bank] = cyc;
            pre_seen[cmd_bank] = 1'b0;
         end
         if (cmd_code == CMD_PRE) begin pre_cyc[cmd_bank] = cyc; pre_seen[cmd_bank] = 1'b1; end
         if (cmd_code == CMD_RD || cmd_code == CMD_WR) begin
            chk(m_open[cmd_bank] && m_row[cmd_bank] == cmd_row, "R4 column to open row",
                m_row[cmd_bank], cmd_row);
            chk(cyc - act_cyc[cmd_bank] >= T_RCD, "R7 activate gap", cyc - act_cyc[cmd_bank], T_RCD);
            last_row = cmd_row; last_bank = cmd_bank; last_col = cmd_col;
         end
      end
   end

   logic [DATA_W-1:0] shadow [NWORD];

   task automatic do_req(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] wd, input logic [1:0] fn,
                         output bit got, output logic [DATA_W-1:0] rd);
      got = 1'b0; rd = '0;
      @(negedge clk);
      log_n = 0;
      req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd; req_fn = fn;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R11 busy after accept", req_ready, 0);
      for (int i = 0; i < 80; i++) begin
         if (rsp_valid) begin got = 1'b1; rd = rsp_data; end
         if (req_ready) break;
         @(negedge clk);
      end
      chk(req_ready == 1'b1, "R11 request completes", req_ready, 1);
   endtask

   task automatic t_reset;
      chk(req_ready == 1'b1, "R2 ready after reset", req_ready, 1);
      chk(cmd_code == CMD_NOP, "R2 no command after reset", cmd_code, CMD_NOP);
      chk(rsp_valid == 1'b0, "R2 no response after reset", rsp_valid, 0);
   endtask

   task automatic t_read(input int row, input int bank, input int col, input int exp_n,
                         input string tag);
      bit got; logic [DATA_W-1:0] rd;
      logic [ADDR_W-1:0] a = mk(row, bank, col);
      do_req(OP_READ, a, '0, 2'd0, got, rd);
      chk(got, {tag, " response seen"}, got, 1);
      chk(rd == shadow[a], {tag, " R9 read data"}, rd, shadow[a]);
      chk(log_n == exp_n, {tag, " command count"}, log_n, exp_n);
      chk(log_code[log_n-1] == CMD_RD, {tag, " last is read"}, log_code[log_n-1], CMD_RD);
      chk({last_row, last_bank, last_col} == a, "R1 address fields", {last_row, last_bank, last_col}, a);
   endtask

   task automatic t_first_access;
      t_read(2, 0, 1, 2, "R3");
      chk(log_code[0] == CMD_ACT, "R3 activate without precharge", log_code[0], CMD_ACT);
   endtask

   task automatic t_hit;
      t_read(2, 0, 5, 1, "R4");
   endtask

   task automatic t_banks;
      t_read(7, 1, 3, 2, "R6 open bank1");
      t_read(2, 0, 0, 1, "R6 bank0 still open");
      t_read(7, 1, 6, 1, "R6 bank1 still open");
   endtask

   task automatic t_miss;
      t_read(9, 0, 6, 3, "R5");
      chk(log_code[0] == CMD_PRE && log_code[1] == CMD_ACT, "R5 order", log_code[0], CMD_PRE);
      chk(log_cyc[1] - log_cyc[0] == T_RP, "R7 exact precharge gap", log_cyc[1] - log_cyc[0], T_RP);
      chk(log_cyc[2] - log_cyc[1] == T_RCD, "R7 exact activate gap", log_cyc[2] - log_cyc[1], T_RCD);
   endtask

   task automatic t_write(input int row, input int bank, input int col,
                          input logic [DATA_W-1:0] v, input int exp_n);
      bit got; logic [DATA_W-1:0] rd;
      logic [ADDR_W-1:0] a = mk(row, bank, col);
      do_req(OP_WRITE, a, v, 2'd0, got, rd);
      shadow[a] = v;
      chk(!got, "R8 write gives no response", got, 0);
      chk(log_n == exp_n, "R8 write command count", log_n, exp_n);
      chk(log_code[log_n-1] == CMD_WR, "R8 ends with write", log_code[log_n-1], CMD_WR);
   endtask

   task automatic t_write_read;
      t_write(3, 2, 4, 16'hBEEF, 2);
      t_read(3, 2, 4, 1, "R8 readback");
      t_write(5, 2, 4, 16'h1234, 3);
      t_read(3, 2, 4, 3, "R8 other row kept");
      t_read(5, 2, 4, 3, "R8 second row");
   endtask

   task automatic t_rmw(input int row, input int bank, input int col, input logic [1:0] fn,
                        input logic [DATA_W-1:0] opnd, input int exp_n);
      bit got; logic [DATA_W-1:0] rd, exp;
      logic [ADDR_W-1:0] a = mk(row, bank, col);
      case (fn)
         2'd0: exp = shadow[a] + opnd;
         2'd1: exp = shadow[a] | opnd;
         2'd2: exp = shadow[a] & opnd;
         default: exp = shadow[a];
      endcase
      do_req(OP_RMW, a, opnd, fn, got, rd);
      shadow[a] = exp;
      chk(got && rd == exp, "R10 modified result", rd, exp);
      chk(log_n == exp_n, "R10 command count", log_n, exp_n);
      chk(log_code[log_n-2] == CMD_RD && log_code[log_n-1] == CMD_WR, "R10 read then write",
          log_code[log_n-1], CMD_WR);
      t_read(row, bank, col, 1, "R10 stored result");
   endtask

   initial begin : watchdog
      #(CLK_NS * 100000);
      bad++; total++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < NWORD; i++) shadow[i] = init_word(i);
      for (int b = 0; b < NBANK; b++) begin pre_cyc[b] = 0; act_cyc[b] = 0; pre_seen[b] = 1'b0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_first_access();
      t_hit();
      t_banks();
      t_miss();
      t_write_read();
      t_rmw(9, 0, 6, 2'd0, 16'h0011, 2);
      t_rmw(9, 0, 2, 2'd1, 16'h8001, 2);
      t_rmw(4, 3, 7, 2'd2, 16'h00F0, 3);
      t_rmw(4, 3, 1, 2'd3, 16'hFFFF, 2);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule